// File: doc/BRIEF.md
# Merging store buffer with load forwarding

The block sits between a load/store pipe and a memory write bus for memory whose reads and writes have no side effects. Stores are parked in a few line-wide entries. A store to a line that already has an open entry is folded into it byte by byte, so repeated writes to one location and writes to adjacent bytes of a line leave as a single bus write that carries the final bytes under a combined strobe. Entries drain to the bus one at a time. Entries for different lines may leave in any order, but entries for the same line always leave in the order they were accepted.

Loads are compared against every pending byte. A load whose requested bytes are all buffered is answered in the same cycle from the newest buffered copy of each byte. A load that shares no byte with the buffer is let through so the pipe can read memory. A load that is only partly covered is held back until the overlapping entries have drained. A barrier request blocks all new loads and stores and switches the drain to oldest-first until the buffer is empty.

Top module: `store_merge_buf`

## Requirements
- R1: After reset the buffer is empty: `st_ready`=1, `wr_valid`=0, `bar_busy`=0, and any load gets `ld_ready`=1, `ld_hit`=0.
- R2: Addresses are byte addresses. The line is `addr[ADDR_W-1:3]` and the low three bits are ignored. Byte lane i is `data[8i+7:8i]`, enabled by `be[i]`. A store to a line that has an entry not yet chosen for the bus merges into it: its enabled lanes overwrite, and the entry's strobe becomes the OR of both strobes. The line leaves as one write with address `line<<3`, the merged strobe, and zero in lanes that were never written.
- R3: A store to a line whose entry is already chosen for the bus takes a new entry. Writes to the same line reach the bus in acceptance order.
- R4: A load (`ld_valid`=1) whose enabled bytes are all buffered gets `ld_ready`=1 and `ld_hit`=1 in the same cycle. `ld_data` carries the newest buffered value of each enabled lane and zero in the other lanes.
- R5: A load that shares no enabled byte with any pending entry gets `ld_ready`=1 and `ld_hit`=0.
- R6: A load with some but not all enabled bytes buffered gets `ld_ready`=0 until the overlapping entries have drained.
- R7: With all four entries in use, a store to a line without an open entry sees `st_ready`=0. A store that merges into an open entry is still accepted.
- R8: Without a barrier, the entry drained next is the lowest-numbered entry that has no older entry for the same line. New stores take the lowest free slot. A younger store can therefore reach the bus before older stores to other lines.
- R9: From the cycle `bar_req` is high until the buffer is empty, `st_ready`=0 and `ld_ready`=0, and entries drain strictly oldest first. `bar_busy` is 1 from the next cycle while entries remain, and it drops one cycle after the last entry is freed.
- R10: `wr_valid` holds with a stable address, strobe and data until `wr_ready`. Only one write is outstanding. Its entry is freed on the `wr_ack` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store byte address |
| st_be | input | DATA_W/8 | Store byte enables |
| st_data | input | DATA_W | Store data, lane-aligned |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | ADDR_W | Load byte address |
| ld_be | input | DATA_W/8 | Load byte enables |
| ld_ready | output | 1 | Load may proceed (low = stall) |
| ld_hit | output | 1 | Load fully answered from the buffer |
| ld_data | output | DATA_W | Forwarded load data |
| bar_req | input | 1 | Barrier request |
| bar_busy | output | 1 | Barrier drain in progress |
| wr_valid | output | 1 | Bus write request |
| wr_ready | input | 1 | Bus accepts the write |
| wr_addr | output | ADDR_W | Line-aligned write address |
| wr_strb | output | DATA_W/8 | Write byte strobe |
| wr_data | output | DATA_W | Write data |
| wr_ack | input | 1 | One-cycle write completion |

## Verification
`st_ready`, `ld_ready`, `ld_hit` and `ld_data` are combinational, so the bench reads them 1 ns after the falling edge at which it drives the request, in that same cycle. A store accepted at one edge is picked for the bus at the next edge and shows on `wr_valid` from then on. Its slot is freed at the edge where `wr_ack` is high, and `bar_busy` falls one edge after that. Write order is therefore checked against a log kept by the bench's bus model, which waits until the expected number of writes has arrived rather than counting cycles. Checks that depend on a slot being freed are made only after the log shows the write.

// File: rtl/smb_pkg.sv
package smb_pkg;

    // Drain sequencer: pick an entry, present it, wait for the acknowledge.
    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_SEND = 2'd1,
        DR_WAIT = 2'd2
    } drain_e;

endpackage

// File: rtl/smb_fwd.sv
// Per-byte hazard compare and forwarding of the newest buffered byte.
module smb_fwd #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 29,
    parameter int NB      = 8,
    parameter int AGE_W   = 2
) (
    input  logic [ENTRIES-1:0]                ent_valid,
    input  logic [ENTRIES-1:0][LINE_W-1:0]    ent_line,
    input  logic [ENTRIES-1:0][NB-1:0]        ent_bv,
    input  logic [ENTRIES-1:0][NB-1:0][7:0]   ent_data,
    input  logic [ENTRIES-1:0][AGE_W-1:0]     ent_age,
    input  logic [LINE_W-1:0]                 ld_line,
    input  logic [NB-1:0]                     ld_be,
    output logic                              full_hit,
    output logic                              partial,
    output logic [NB-1:0][7:0]                fwd_data
);

    logic [NB-1:0]            found;
    logic [NB-1:0][AGE_W-1:0] best_age;
    logic [NB-1:0][7:0]       best_byte;

    always_comb begin
        found     = '0;
        best_age  = '0;
        best_byte = '0;
        for (int b = 0; b < NB; b++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (ent_valid[e] && (ent_line[e] == ld_line) && ent_bv[e][b] &&
                    (!found[b] || (ent_age[e] > best_age[b]))) begin
                    found[b]     = 1'b1;
                    best_age[b]  = ent_age[e];
                    best_byte[b] = ent_data[e][b];
                end
            end
            fwd_data[b] = ld_be[b] ? best_byte[b] : 8'h00;
        end
    end

    assign full_hit = (ld_be != '0) && ((ld_be & ~found) == '0);
    assign partial  = ((ld_be & found) != '0) && !full_hit;

endmodule

// File: rtl/smb_pick.sv
// Drain selection: oldest entry under a barrier, else lowest hazard-free entry.
module smb_pick #(
    parameter int ENTRIES = 4,
    parameter int LINE_W  = 29,
    parameter int AGE_W   = 2,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][LINE_W-1:0] ent_line,
    input  logic [ENTRIES-1:0][AGE_W-1:0]  ent_age,
    input  logic                           oldest_mode,
    output logic                           pick_ok,
    output logic [IDX_W-1:0]               pick_idx
);

    logic [ENTRIES-1:0] elig;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (oldest_mode) begin
                elig[i] = ent_valid[i] && (ent_age[i] == '0);
            end else begin
                elig[i] = ent_valid[i];
                for (int j = 0; j < ENTRIES; j++) begin
                    if ((j != i) && ent_valid[j] && (ent_line[j] == ent_line[i]) &&
                        (ent_age[j] < ent_age[i])) begin
                        elig[i] = 1'b0;
                    end
                end
            end
        end
        pick_ok  = |elig;
        pick_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (elig[i]) pick_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
    import smb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W/8-1:0] st_be,
    input  logic [DATA_W-1:0] st_data,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W/8-1:0] ld_be,
    output logic              ld_ready,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    input  logic              bar_req,
    output logic              bar_busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W/8-1:0] wr_strb,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack
);

    localparam int NB     = DATA_W / 8;
    localparam int OFF_W  = $clog2(NB);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int AGE_W  = IDX_W;
    localparam int CNT_W  = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic [ENTRIES-1:0]              valid;
        logic [ENTRIES-1:0][LINE_W-1:0]  line;
        logic [ENTRIES-1:0][NB-1:0]      bv;
        logic [ENTRIES-1:0][NB-1:0][7:0] data;
        logic [ENTRIES-1:0][AGE_W-1:0]   age;
        drain_e                          dst;
        logic [IDX_W-1:0]                sel;
        logic                            bar_pend;
    } state_t;

    state_t s_q, s_d;

    logic [LINE_W-1:0]   st_line, ld_line;
    logic [NB-1:0][7:0]  st_bytes;
    logic [NB-1:0][7:0]  fwd_bytes;
    logic                block, st_acc;
    logic                fwd_full, fwd_partial;
    logic                pick_ok;
    logic [IDX_W-1:0]    pick_idx;
    logic [ENTRIES-1:0]  locked, free_mask;
    logic                merge_any, free_any;
    logic [IDX_W-1:0]    merge_idx, free_idx;
    logic [CNT_W-1:0]    live_cnt;
    logic                unused_lo;

    assign st_line   = st_addr[ADDR_W-1:OFF_W];
    assign ld_line   = ld_addr[ADDR_W-1:OFF_W];
    assign st_bytes  = st_data;
    assign unused_lo = ^{st_addr[OFF_W-1:0], ld_addr[OFF_W-1:0]};
    assign block     = bar_req | s_q.bar_pend;

    // An entry chosen for the bus is closed to merging.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_lock
        assign locked[g] = (s_q.dst != DR_IDLE) && (s_q.sel == IDX_W'(g));
    end

    always_comb begin
        merge_any = 1'b0;
        merge_idx = '0;
        free_any  = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (s_q.valid[i] && !locked[i] && (s_q.line[i] == st_line)) begin
                merge_any = 1'b1;
                merge_idx = IDX_W'(i);
            end
            if (!s_q.valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign st_ready = !block && (merge_any || free_any);
    assign st_acc   = st_valid && st_ready;

    smb_fwd #(
        .ENTRIES(ENTRIES), .LINE_W(LINE_W), .NB(NB), .AGE_W(AGE_W)
    ) u_fwd (
        .ent_valid (s_q.valid),
        .ent_line  (s_q.line),
        .ent_bv    (s_q.bv),
        .ent_data  (s_q.data),
        .ent_age   (s_q.age),
        .ld_line   (ld_line),
        .ld_be     (ld_be),
        .full_hit  (fwd_full),
        .partial   (fwd_partial),
        .fwd_data  (fwd_bytes)
    );

    assign ld_ready = !block && !fwd_partial;
    assign ld_hit   = ld_valid && fwd_full && !block;
    assign ld_data  = fwd_bytes;

    smb_pick #(
        .ENTRIES(ENTRIES), .LINE_W(LINE_W), .AGE_W(AGE_W), .IDX_W(IDX_W)
    ) u_pick (
        .ent_valid   (s_q.valid),
        .ent_line    (s_q.line),
        .ent_age     (s_q.age),
        .oldest_mode (block),
        .pick_ok     (pick_ok),
        .pick_idx    (pick_idx)
    );

    assign wr_valid = (s_q.dst == DR_SEND);
    assign wr_addr  = {s_q.line[s_q.sel], {OFF_W{1'b0}}};
    assign wr_strb  = s_q.bv[s_q.sel];
    assign wr_data  = s_q.data[s_q.sel];
    assign bar_busy = s_q.bar_pend;

    always_comb begin
        s_d       = s_q;
        free_mask = '0;
        case (s_q.dst)
            DR_IDLE: if (pick_ok) begin
                s_d.sel = pick_idx;
                s_d.dst = DR_SEND;
            end
            DR_SEND: if (wr_ready) s_d.dst = DR_WAIT;
            DR_WAIT: if (wr_ack) begin
                free_mask[s_q.sel] = 1'b1;
                s_d.dst            = DR_IDLE;
            end
            default: s_d.dst = DR_IDLE;
        endcase

        // Retire the acknowledged entry and close the age gap it leaves.
        live_cnt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (free_mask[i]) begin
                s_d.valid[i] = 1'b0;
                s_d.bv[i]    = '0;
            end else if (s_q.valid[i]) begin
                live_cnt = live_cnt + CNT_W'(1);
                if ((free_mask != '0) && (s_q.age[i] > s_q.age[s_q.sel]))
                    s_d.age[i] = s_q.age[i] - AGE_W'(1);
            end
        end

        if (st_acc) begin
            if (merge_any) begin
                for (int b = 0; b < NB; b++) begin
                    if (st_be[b]) s_d.data[merge_idx][b] = st_bytes[b];
                end
                s_d.bv[merge_idx] = s_q.bv[merge_idx] | st_be;
            end else begin
                s_d.valid[free_idx] = 1'b1;
                s_d.line[free_idx]  = st_line;
                s_d.bv[free_idx]    = st_be;
                s_d.age[free_idx]   = AGE_W'(live_cnt);
                for (int b = 0; b < NB; b++) begin
                    s_d.data[free_idx][b] = st_be[b] ? st_bytes[b] : 8'h00;
                end
            end
        end

        s_d.bar_pend = (s_q.bar_pend | bar_req) & (s_q.valid != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.valid    <= '0;
            s_q.line     <= '0;
            s_q.bv       <= '0;
            s_q.data     <= '0;
            s_q.age      <= '0;
            s_q.dst      <= DR_IDLE;
            s_q.sel      <= '0;
            s_q.bar_pend <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // ---------------- assertions ----------------
    logic sel_has_older, age_dup;

    always_comb begin
        sel_has_older = 1'b0;
        age_dup       = 1'b0;
        for (int j = 0; j < ENTRIES; j++) begin
            if ((IDX_W'(j) != s_q.sel) && s_q.valid[j] &&
                (s_q.line[j] == s_q.line[s_q.sel]) && (s_q.age[j] < s_q.age[s_q.sel]))
                sel_has_older = 1'b1;
            for (int k = j + 1; k < ENTRIES; k++) begin
                if (s_q.valid[j] && s_q.valid[k] && (s_q.age[j] == s_q.age[k]))
                    age_dup = 1'b1;
            end
        end
    end

    // R10
    wr_payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_strb) && $stable(wr_data)));

    // R10
    ack_only_when_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> (s_q.dst == DR_WAIT));

    // R3
    same_line_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |-> !sel_has_older);

    // R8
    unique_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !age_dup);

    // R4
    hit_never_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |-> ld_ready);

    // R9
    barrier_release_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bar_busy) |-> (s_q.valid == '0));

endmodule

// File: tb/store_merge_buf_tb.sv
`timescale 1ns/100ps
module store_merge_buf_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0, ld_valid = 1'b0, bar_req = 1'b0;
    logic [31:0] st_addr = '0, ld_addr = '0;
    logic [7:0]  st_be = '0, ld_be = '0;
    logic [63:0] st_data = '0;
    logic        st_ready, ld_ready, ld_hit, bar_busy, wr_valid;
    logic [63:0] ld_data, wr_data;
    logic [31:0] wr_addr;
    logic [7:0]  wr_strb;
    logic        wr_ready = 1'b0, wr_ack = 1'b0;

    int          n_chk = 0, n_err = 0;
    int          credits = 0;
    int          nlog = 0;
    bit          done = 1'b0;
    logic        hs_prev = 1'b0;
    logic [31:0] lg_addr [0:15];
    logic [7:0]  lg_strb [0:15];
    logic [63:0] lg_data [0:15];

    always #2.5 clk = ~clk;

    store_merge_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_be(st_be), .st_data(st_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
        .ld_ready(ld_ready), .ld_hit(ld_hit), .ld_data(ld_data),
        .bar_req(bar_req), .bar_busy(bar_busy),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_strb(wr_strb),
        .wr_data(wr_data), .wr_ack(wr_ack)
    );

    // Bus model: ready while credits remain, acknowledge one cycle after the handshake.
    always @(negedge clk) begin
        wr_ack   = hs_prev;
        wr_ready = (credits > 0);
        hs_prev  = rst_n && wr_valid && wr_ready;
        if (hs_prev) begin
            if (nlog < 16) begin
                lg_addr[nlog] = wr_addr;
                lg_strb[nlog] = wr_strb;
                lg_data[nlog] = wr_data;
            end
            nlog++;
            credits--;
        end
    end

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic store(input logic [31:0] a, input logic [7:0] be, input logic [63:0] d,
                         input logic exp_rdy, input string tag);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_be = be; st_data = d;
        #1;
        chk_eq(tag, st_ready, exp_rdy);
        @(posedge clk);
        #1;
        st_valid = 1'b0;
    endtask

    task automatic load(input logic [31:0] a, input logic [7:0] be, input logic exp_rdy,
                        input logic exp_hit, input logic [63:0] exp_d, input string tag);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_be = be;
        #1;
        chk_eq({tag, " ld_ready"}, ld_ready, exp_rdy);
        chk_eq({tag, " ld_hit"}, ld_hit, exp_hit);
        if (exp_hit) chk_eq({tag, " ld_data"}, ld_data, exp_d);
        ld_valid = 1'b0;
    endtask

    task automatic wait_log(input int n, input string tag);
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            #1;
            if (nlog >= n) break;
        end
        tick(4);
        chk_eq({tag, " write count"}, nlog, n);
    endtask

    task automatic chk_wr(input int i, input logic [31:0] a, input logic [7:0] s,
                          input logic [63:0] d, input string tag);
        chk_eq({tag, " addr"}, lg_addr[i], a);
        chk_eq({tag, " strb"}, lg_strb[i], s);
        chk_eq({tag, " data"}, lg_data[i], d);
    endtask

    task automatic t_reset;
        @(negedge clk);
        #1;
        chk_eq("R1 st_ready", st_ready, 1'b1);
        chk_eq("R1 wr_valid", wr_valid, 1'b0);
        chk_eq("R1 bar_busy", bar_busy, 1'b0);
        load(32'h0, 8'hFF, 1'b1, 1'b0, 64'h0, "R1 empty load");
    endtask

    task automatic t_merge;
        credits = 0; nlog = 0;
        store(32'h100, 8'h0F, 64'hA5A5A5A5_01234567, 1'b1, "R2 store A");
        store(32'h200, 8'h0F, 64'h11111111_22222222, 1'b1, "R2 store B1");
        store(32'h204, 8'hF0, 64'h33333333_44444444, 1'b1, "R2 store B2 offset ignored");
        store(32'h200, 8'h01, 64'h00000000_000000AA, 1'b1, "R2 store B3 overwrite");
        load(32'h200, 8'hFF, 1'b1, 1'b1, 64'h33333333_222222AA, "R4 merged hit");
        load(32'h100, 8'h03, 1'b1, 1'b1, 64'h00000000_00004567, "R4 hit on entry on bus");
        load(32'h300, 8'hFF, 1'b1, 1'b0, 64'h0, "R5 miss");
        credits = 1000;
        wait_log(2, "R2");
        chk_wr(0, 32'h100, 8'h0F, 64'h00000000_01234567, "R2 first write");
        chk_wr(1, 32'h200, 8'hFF, 64'h33333333_222222AA, "R2 merged write");
        load(32'h200, 8'hFF, 1'b1, 1'b0, 64'h0, "R10 freed after ack");
    endtask

    task automatic t_same_line;
        credits = 0; nlog = 0;
        store(32'h400, 8'h0F, 64'h00000000_11111111, 1'b1, "R3 store C");
        tick(3);
        store(32'h400, 8'h03, 64'h00000000_00005555, 1'b1, "R3 store C2 new entry");
        load(32'h400, 8'hFF, 1'b0, 1'b0, 64'h0, "R6 partial stall");
        load(32'h400, 8'h0F, 1'b1, 1'b1, 64'h00000000_11115555, "R3 newest byte wins");
        load(32'h404, 8'hF0, 1'b1, 1'b0, 64'h0, "R5 disjoint bytes");
        credits = 1000;
        wait_log(2, "R3");
        chk_wr(0, 32'h400, 8'h0F, 64'h00000000_11111111, "R3 older write first");
        chk_wr(1, 32'h400, 8'h03, 64'h00000000_00005555, "R3 younger write second");
        load(32'h400, 8'hFF, 1'b1, 1'b0, 64'h0, "R6 released after drain");
    endtask

    task automatic fill_four(input string tag);
        credits = 0; nlog = 0;
        store(32'h700, 8'hFF, 64'h07070707_07070707, 1'b1, {tag, " S1"});
        store(32'h800, 8'hFF, 64'h08080808_08080808, 1'b1, {tag, " S2"});
        store(32'h900, 8'hFF, 64'h09090909_09090909, 1'b1, {tag, " S3"});
        store(32'hA00, 8'hFF, 64'h0A0A0A0A_0A0A0A0A, 1'b1, {tag, " S4"});
    endtask

    task automatic t_reorder;
        fill_four("R8");
        store(32'hB00, 8'hFF, 64'h0B0B0B0B_0B0B0B0B, 1'b0, "R7 full new line refused");
        store(32'h800, 8'h01, 64'h00000000_000000EE, 1'b1, "R7 full merge accepted");
        credits = 1;
        tick(8);
        chk_eq("R10 one write", nlog, 1);
        store(32'hC00, 8'hFF, 64'h0C0C0C0C_0C0C0C0C, 1'b1, "R8 S6 into freed slot");
        credits = 1000;
        wait_log(5, "R8");
        chk_eq("R8 order 0", lg_addr[0], 32'h700);
        chk_wr(1, 32'h800, 8'hFF, 64'h08080808_080808EE, "R7 merged while full");
        chk_eq("R8 younger overtakes", lg_addr[2], 32'hC00);
        chk_eq("R8 order 3", lg_addr[3], 32'h900);
        chk_eq("R8 order 4", lg_addr[4], 32'hA00);
    endtask

    task automatic t_barrier;
        fill_four("R9");
        credits = 1;
        tick(8);
        store(32'hC00, 8'hFF, 64'h0C0C0C0C_0C0C0C0C, 1'b1, "R9 S6");
        @(negedge clk);
        bar_req = 1'b1;
        st_valid = 1'b1; st_addr = 32'hD00; st_be = 8'hFF; st_data = 64'h0D;
        ld_valid = 1'b1; ld_addr = 32'h900; ld_be = 8'hFF;
        #1;
        chk_eq("R9 store blocked on request", st_ready, 1'b0);
        chk_eq("R9 load blocked on request", ld_ready, 1'b0);
        @(posedge clk);
        #1;
        bar_req = 1'b0;
        @(negedge clk);
        #1;
        chk_eq("R9 bar_busy", bar_busy, 1'b1);
        chk_eq("R9 store blocked while busy", st_ready, 1'b0);
        chk_eq("R9 load blocked while busy", ld_ready, 1'b0);
        st_valid = 1'b0; ld_valid = 1'b0;
        credits = 1000;
        wait_log(5, "R9");
        chk_eq("R9 order 2", lg_addr[2], 32'h900);
        chk_eq("R9 order 3", lg_addr[3], 32'hA00);
        chk_eq("R9 order 4 youngest last", lg_addr[4], 32'hC00);
        chk_eq("R9 bar_busy cleared", bar_busy, 1'b0);
        chk_eq("R9 store ready again", st_ready, 1'b1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_merge;
        t_same_line;
        t_reorder;
        t_barrier;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule